// File: doc/BRIEF.md
# Contactless Target Initialization Responder

This block is the card side of the ISO/IEC 14443-3A initialization phase. It works on frames that a bit-level decoder upstream has already turned into bytes. It returns its answers as bytes to a framer downstream. It wakes on a request, answers with a programmable ATQA and takes part in single-size anticollision with a 4-byte identifier. When a reader selects it, it returns a programmable SAK, enters the active state and may interrupt the host. From that point on the host handles every frame.

The identifier is not a factory serial number. Its first byte is always 08h. The other three bytes come from a free-running 24-bit LFSR, which is sampled each time a new session starts (a pulse on `sess_start`, typically field-on). Collisions between two such targets therefore do not repeat from one session to the next. Only cascade level 1 exists, so frames for the deeper cascade levels get no answer.

The upstream decoder removes CRC_A before a frame arrives, and the framer downstream appends CRC_A where the protocol calls for it. `tx_align` gives the framer the number of low bits of the first response byte that it must drop. This is how a split-byte anticollision answer is sent.

Top module: `tgt_anticoll`

## Requirements
- R1: The identifier is made of the bytes uid0=08h, uid1=rnd[7:0], uid2=rnd[15:8] and uid3=rnd[23:16]. A fifth check byte follows it, equal to uid0^uid1^uid2^uid3. These five bytes form positions 0..4 of the anticollision answer.
- R2: The LFSR resets to SEED. On every clock it shifts left, and its new bit 0 is the XOR of bits 23, 22, 21 and 16. Reset loads rnd with SEED. A clock edge that samples `sess_start` high copies the LFSR value held before that edge into rnd, returns the target to IDLE and stops any response in progress.
- R3: In IDLE, a 1-byte short frame (`rx_short`=1) of 26h or 52h moves the target to READY and returns 2 ATQA bytes, low byte first. Any other frame in IDLE gets no answer.
- R4: In READY, the frame 93h, NVB arrives with NVB = {nb, nbits}, 2≤nb≤6 and nbits≤7. The frame must be nb bytes long, plus one more when nbits≠0. The target compares the nb−2 full identifier bytes it receives and the low nbits bits of any partial byte; the higher bits of the partial byte are ignored. If they all match, it answers with positions nb−2..4, and `tx_align`=nbits on the first byte.
- R5: An anticollision frame whose known bits do not match gets no answer, and the target stays in READY.
- R6: A 7-byte frame 93h 70h uid0..uid3 check, fully matching, returns a 1-byte SAK and enters ACTIVE. A non-matching one gets no answer and leaves the target in READY.
- R7: The SAK sent is the configured SAK with bit 2 forced to 0 and bit 5 replaced by the protocol-capable flag.
- R8: `irq` pulses for exactly one cycle when ACTIVE is entered, and only if the interrupt enable is set.
- R9: In READY, any other frame, including 95h or 97h cascade frames and malformed NVB values, gets no answer. The target goes back to IDLE, or to HALT if it was woken from HALT.
- R10: `active` is high exactly in ACTIVE. There, the 2-byte frame 50h 00h moves the target to HALT without an answer, and every other frame is left to the host without an answer.
- R11: In HALT only a short 52h frame wakes the target, with the ATQA answer. 26h and every other frame are ignored.
- R12: The configuration writes are: address 0 sets ATQA[7:0], address 1 sets ATQA[15:8], address 2 sets the SAK, and address 3 sets control, where bit 0 is the interrupt enable and bit 1 is the protocol-capable flag. Reset values are ATQA=0004h, SAK=00h and control=0.
- R13: An answer starts on the cycle after the clock edge that samples the last received byte. It sends one byte per cycle with `tx_valid` high, and `tx_last` marks the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sess_start | input | 1 | Session start pulse; resamples the identifier |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Last byte of the frame |
| rx_short | input | 1 | Frame is a 7-bit short frame |
| tx_valid | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_last | output | 1 | Final response byte |
| tx_align | output | 3 | Low bits of the first byte the framer drops |
| active | output | 1 | Target is selected |
| irq | output | 1 | Selection interrupt pulse |

## Verification
The bench sweeps every legal NVB, from 20h to 67h, twice: once with the correct known bits, with the unused high bits of the partial byte inverted, and once with a single flipped known bit. A design that ignored the partial-byte mask would stay silent on the first pass, and one that skipped the compare would answer on the second. The bench also drives the HALT round trip, a cascade-level-2 frame sent after a HALT wake-up, and a select with a wrong check byte. A target that answered REQA while halted, or fell back to IDLE instead of HALT, would answer where it must not. The bench keeps its own model of the LFSR, so a wrong tap, a wrong byte order or a sample taken one cycle off shows up as a wrong identifier after a session restart.

// File: rtl/tgt_anticoll.sv
`timescale 1ns/1ps
module tgt_anticoll #(
  parameter logic [23:0] SEED   = 24'h5A5A5A,
  parameter logic [7:0]  PREFIX = 8'h08
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sess_start,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_last,
  input  logic       rx_short,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic [2:0] tx_align,
  output logic       active,
  output logic       irq
);
  typedef enum logic [1:0] {S_IDLE = 2'd0, S_READY = 2'd1, S_ACTIVE = 2'd2, S_HALT = 2'd3} st_t;
  typedef enum logic [1:0] {K_ATQA = 2'd0, K_UID = 2'd1, K_SAK = 2'd2} kind_t;

  st_t         st;
  kind_t       kind;
  logic [23:0] lfsr, rnd;
  logic [15:0] atqa;
  logic [7:0]  sak_cfg, cmd, nvb;
  logic        irq_en, l4, woke_halt;
  logic [2:0]  rcnt, ptr, stop, align;
  logic        ok, long_f, tx_on, first;
  logic [7:0]  uid [0:7];

  always_comb begin
    uid[0] = PREFIX;
    uid[1] = rnd[7:0];
    uid[2] = rnd[15:8];
    uid[3] = rnd[23:16];
    uid[4] = PREFIX ^ rnd[7:0] ^ rnd[15:8] ^ rnd[23:16];
    uid[5] = 8'h00;
    uid[6] = 8'h00;
    uid[7] = 8'h00;
  end

  wire [7:0] sak_tx  = {sak_cfg[7:6], l4, sak_cfg[4:3], 1'b0, sak_cfg[1:0]};
  wire [7:0] cur_cmd = (rcnt == 3'd0) ? rx_data : cmd;
  wire [7:0] cur_nvb = (rcnt == 3'd1) ? rx_data : nvb;
  wire [3:0] nb      = cur_nvb[7:4];
  wire [3:0] nbits   = cur_nvb[3:0];
  wire [3:0] full    = nb - 4'd2;
  wire [2:0] pos     = rcnt - 3'd2;
  wire [7:0] mask    = (8'd1 << nbits[2:0]) - 8'd1;
  wire [3:0] len     = {1'b0, rcnt} + 4'd1;
  wire [3:0] ac_len  = nb + {3'd0, nbits != 4'd0};

  logic byte_ok;
  always_comb begin
    if (rcnt < 3'd2)                                   byte_ok = 1'b1;
    else if ({1'b0, pos} < full)                       byte_ok = (rx_data == uid[pos]);
    else if ({1'b0, pos} == full && nbits != 4'd0 && nbits < 4'd8)
                                                       byte_ok = ((rx_data ^ uid[pos]) & mask) == 8'h00;
    else                                               byte_ok = 1'b0;
  end

  wire fend   = rx_valid && rx_last && !sess_start;
  wire match  = ok && byte_ok;
  wire shrt1  = rx_short && rcnt == 3'd0 && !long_f;
  wire reqa   = shrt1 && rx_data == 8'h26;
  wire wupa   = shrt1 && rx_data == 8'h52;
  wire norm   = !rx_short && !long_f;
  wire hlta   = norm && rcnt == 3'd1 && cmd == 8'h50 && rx_data == 8'h00;
  wire ac_ok  = norm && rcnt >= 3'd1 && cur_cmd == 8'h93 && nb >= 4'd2 && nb <= 4'd6 &&
                nbits <= 4'd7 && len == ac_len;
  wire sel_ok = norm && rcnt == 3'd6 && cmd == 8'h93 && nvb == 8'h70;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atqa    <= 16'h0004;
      sak_cfg <= 8'h00;
      irq_en  <= 1'b0;
      l4      <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: atqa[7:0]  <= cfg_wdata;
        2'd1: atqa[15:8] <= cfg_wdata;
        2'd2: sak_cfg    <= cfg_wdata;
        default: begin
          irq_en <= cfg_wdata[0];
          l4     <= cfg_wdata[1];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt   <= 3'd0;
      cmd    <= 8'h00;
      nvb    <= 8'h00;
      ok     <= 1'b0;
      long_f <= 1'b0;
    end else if (sess_start || (rx_valid && rx_last)) begin
      rcnt   <= 3'd0;
      long_f <= 1'b0;
    end else if (rx_valid) begin
      if (rcnt == 3'd0) cmd <= rx_data;
      if (rcnt == 3'd1) nvb <= rx_data;
      ok <= (rcnt == 3'd0) ? 1'b1 : match;
      if (rcnt == 3'd7) long_f <= 1'b1;
      else              rcnt   <= rcnt + 3'd1;
    end
  end

  task automatic start_tx(input kind_t k, input logic [2:0] p, input logic [2:0] s, input logic [2:0] a);
    tx_on <= 1'b1;
    first <= 1'b1;
    kind  <= k;
    ptr   <= p;
    stop  <= s;
    align <= a;
  endtask

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rnd <= SEED; woke_halt <= 1'b0; irq <= 1'b0;
      tx_on <= 1'b0; first <= 1'b0; kind <= K_ATQA; ptr <= 3'd0; stop <= 3'd0; align <= 3'd0;
    end else if (sess_start) begin
      st <= S_IDLE; rnd <= lfsr; woke_halt <= 1'b0; irq <= 1'b0; tx_on <= 1'b0; first <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (tx_on) begin
        first <= 1'b0;
        if (ptr == stop) tx_on <= 1'b0;
        else             ptr   <= ptr + 3'd1;
      end
      if (fend) begin
        case (st)
          S_IDLE: if (reqa || wupa) begin
            st <= S_READY; woke_halt <= 1'b0;
            start_tx(K_ATQA, 3'd0, 3'd1, 3'd0);
          end
          S_HALT: if (wupa) begin
            st <= S_READY; woke_halt <= 1'b1;
            start_tx(K_ATQA, 3'd0, 3'd1, 3'd0);
          end
          S_READY: begin
            if (ac_ok) begin
              if (match) start_tx(K_UID, full[2:0], 3'd4, nbits[2:0]);
            end else if (sel_ok) begin
              if (match) begin
                st  <= S_ACTIVE;
                irq <= irq_en;
                start_tx(K_SAK, 3'd0, 3'd0, 3'd0);
              end
            end else begin
              st <= woke_halt ? S_HALT : S_IDLE;
            end
          end
          default: if (hlta) st <= S_HALT;
        endcase
      end
    end
  end

  always_comb begin
    case (kind)
      K_ATQA:  tx_data = ptr[0] ? atqa[15:8] : atqa[7:0];
      K_SAK:   tx_data = sak_tx;
      default: tx_data = uid[ptr];
    endcase
  end

  assign tx_valid = tx_on;
  assign tx_last  = tx_on && ptr == stop;
  assign tx_align = (tx_on && first) ? align : 3'd0;
  assign active   = st == S_ACTIVE;
endmodule

module tgt_anticoll_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sess_start,
  input logic [1:0] st,
  input logic       rx_valid,
  input logic       rx_last,
  input logic       rx_short,
  input logic [7:0] rx_data,
  input logic       tx_valid,
  input logic       tx_last,
  input logic [2:0] tx_align,
  input logic       active,
  input logic       irq
);
  a_r8_irq_when_active: assert property (@(posedge clk) disable iff (!rst_n) irq |-> active);
  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  a_r13_tx_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last && !(rx_valid && rx_last)) |=> !tx_valid);
  a_r4_align_in_frame: assert property (@(posedge clk) disable iff (!rst_n) (tx_align != 3'd0) |-> tx_valid);
  a_r11_halt_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !sess_start) |=> (st == 2'd3 ||
      (st == 2'd1 && $past(rx_data) == 8'h52 && $past(rx_short) && $past(rx_valid))));
  a_r2_session_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sess_start |=> (st == 2'd0 && !tx_valid && !active));
endmodule

bind tgt_anticoll tgt_anticoll_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .st(st),
  .rx_valid(rx_valid), .rx_last(rx_last), .rx_short(rx_short), .rx_data(rx_data),
  .tx_valid(tx_valid), .tx_last(tx_last), .tx_align(tx_align), .active(active), .irq(irq)
);

// File: tb/tgt_anticoll_bench.sv
`timescale 1ns/1ps
module tgt_anticoll_bench;
  localparam logic [23:0] SEED = 24'h5A5A5A;

  logic clk = 1'b0, rst_n = 1'b0, sess_start = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [7:0] cfg_wdata = 8'h00;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_short = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic tx_valid, tx_last, active, irq;
  logic [7:0] tx_data;
  logic [2:0] tx_align;

  tgt_anticoll #(.SEED(SEED), .PREFIX(8'h08)) u_tgt_anticoll (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_short(rx_short),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_align(tx_align),
    .active(active), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  int rn = 0, rl = -1, irq_cnt = 0;
  logic [7:0] rb [0:7];
  logic [7:0] eb [0:7];
  logic [7:0] fr [0:7];
  logic [2:0] ra = 3'd0;
  logic tv_first = 1'b0;
  logic [23:0] mdl, exp_rnd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdl <= SEED;
      exp_rnd <= SEED;
    end else begin
      mdl <= {mdl[22:0], mdl[23] ^ mdl[22] ^ mdl[21] ^ mdl[16]};
      if (sess_start) exp_rnd <= mdl;
    end
  end

  always @(negedge clk) begin
    if (tx_valid) begin
      if (rn < 8) rb[rn] = tx_data;
      if (rn == 0) ra = tx_align;
      if (tx_last) rl = rn;
      rn++;
    end
    if (irq) irq_cnt++;
  end

  function automatic logic [7:0] ub(input int p);
    case (p)
      0: ub = 8'h08;
      1: ub = exp_rnd[7:0];
      2: ub = exp_rnd[15:8];
      3: ub = exp_rnd[23:16];
      default: ub = 8'h08 ^ exp_rnd[7:0] ^ exp_rnd[15:8] ^ exp_rnd[23:16];
    endcase
  endfunction

  task automatic chk(input bit c, input string req, input int act, input int exp);
    total++;
    if (!c) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int n, input bit sh);
    rn = 0; rl = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = fr[i]; rx_last = (i == n - 1); rx_short = sh;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_short = 1'b0;
    tv_first = tx_valid;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_resp(input string req, input int n, input int al);
    chk(rn == n, {req, " count"}, rn, n);
    if (n > 0 && rn == n) begin
      chk(tv_first, {req, " R13 start"}, tv_first, 1);
      chk(rl == n - 1, {req, " R13 last"}, rl, n - 1);
      chk(ra == al[2:0], {req, " align"}, ra, al);
      for (int i = 0; i < n; i++) chk(rb[i] == eb[i], {req, " byte"}, rb[i], eb[i]);
    end
  endtask

  task automatic short1(input logic [7:0] b);
    fr[0] = b;
    send(1, 1'b1);
  endtask

  task automatic frame2(input logic [7:0] a, input logic [7:0] b);
    fr[0] = a; fr[1] = b;
    send(2, 1'b0);
  endtask

  task automatic expect_atqa(input string req);
    eb[0] = 8'h44; eb[1] = 8'h03;
    check_resp(req, 2, 0);
  endtask

  task automatic full_uid(input string req);
    frame2(8'h93, 8'h20);
    for (int i = 0; i < 5; i++) eb[i] = ub(i);
    check_resp(req, 5, 0);
  endtask

  task automatic select_frame(input bit good);
    fr[0] = 8'h93; fr[1] = 8'h70;
    for (int i = 0; i < 5; i++) fr[2 + i] = ub(i);
    if (!good) fr[6] = fr[6] ^ 8'h01;
    send(7, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [23:0] old_rnd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !active && !irq, "R12 reset outputs", {tx_valid, active, irq}, 0);

    // R3: non-request frame in IDLE ignored; R12: reset ATQA 0004h
    frame2(8'h93, 8'h20);
    check_resp("R3 idle ignore", 0, 0);
    short1(8'h26);
    eb[0] = 8'h04; eb[1] = 8'h00;
    check_resp("R12 reset ATQA", 2, 0);
    // R9 fallback to IDLE via REQA in READY, then configure
    short1(8'h26);
    check_resp("R9 reqa in ready", 0, 0);

    wr(2'd0, 8'h44); wr(2'd1, 8'h03); wr(2'd2, 8'h5C); wr(2'd3, 8'h03);
    short1(8'h26);
    expect_atqa("R3 REQA ATQA");
    full_uid("R1 seed uid");
    chk(ub(0) == 8'h08, "R1 prefix", ub(0), 8'h08);

    // R4/R5 sweep every legal NVB
    for (int nb = 2; nb <= 6; nb++) begin
      for (int bits = 0; bits <= 7; bits++) begin
        int k, n;
        logic [7:0] m;
        k = nb - 2;
        m = (8'd1 << bits) - 8'd1;
        n = nb + ((bits != 0) ? 1 : 0);
        fr[0] = 8'h93; fr[1] = {nb[3:0], bits[3:0]};
        for (int j = 0; j < k; j++) fr[2 + j] = ub(j);
        if (bits != 0) fr[nb] = ub(k) ^ ~m;
        send(n, 1'b0);
        for (int i = 0; i < 5 - k; i++) eb[i] = ub(k + i);
        check_resp("R4 anticoll match", 5 - k, bits);
        if (nb > 2 || bits != 0) begin
          fr[0] = 8'h93; fr[1] = {nb[3:0], bits[3:0]};
          for (int j = 0; j < k; j++) fr[2 + j] = ub(j);
          if (bits != 0) fr[nb] = ub(k) ^ ~m;
          fr[2] = fr[2] ^ 8'h01;
          send(n, 1'b0);
          check_resp("R5 anticoll mismatch", 0, 0);
        end
      end
    end
    full_uid("R5 still ready");

    // R9: cascade level 2 gets silence and drops to IDLE
    frame2(8'h95, 8'h20);
    check_resp("R9 cascade2 silent", 0, 0);
    frame2(8'h93, 8'h20);
    check_resp("R9 back in idle", 0, 0);

    // R6/R7/R8
    short1(8'h52);
    expect_atqa("R3 WUPA ATQA");
    select_frame(1'b0);
    check_resp("R6 bad select silent", 0, 0);
    chk(!active, "R6 bad select inactive", active, 0);
    irq_cnt = 0;
    select_frame(1'b1);
    eb[0] = 8'h78;
    check_resp("R7 SAK value", 1, 0);
    chk(active, "R6 active after select", active, 1);
    chk(irq_cnt == 1, "R8 irq single pulse", irq_cnt, 1);

    // R10
    short1(8'h26);
    check_resp("R10 active ignores reqa", 0, 0);
    chk(active, "R10 stays active", active, 1);
    frame2(8'h50, 8'h00);
    check_resp("R10 halt silent", 0, 0);
    chk(!active, "R10 left active", active, 0);

    // R11 and R9 return to HALT
    short1(8'h26);
    check_resp("R11 halt ignores reqa", 0, 0);
    frame2(8'h93, 8'h20);
    check_resp("R11 halt ignores anticoll", 0, 0);
    short1(8'h52);
    expect_atqa("R11 wupa wakes");
    frame2(8'h97, 8'h20);
    check_resp("R9 cascade3 silent", 0, 0);
    short1(8'h26);
    check_resp("R9 returned to halt", 0, 0);
    short1(8'h52);
    expect_atqa("R11 wupa again");
    full_uid("R11 ready after wake");

    // R2: new session resamples the identifier
    old_rnd = exp_rnd;
    repeat (37) @(negedge clk);
    sess_start = 1'b1;
    @(negedge clk);
    sess_start = 1'b0;
    chk(!tx_valid && !active, "R2 session idle", {tx_valid, active}, 0);
    chk(exp_rnd != old_rnd, "R2 new random", exp_rnd, old_rnd);
    frame2(8'h93, 8'h20);
    check_resp("R2 session idle silent", 0, 0);
    short1(8'h26);
    expect_atqa("R2 reqa after session");
    full_uid("R2 resampled uid");

    // R8 disabled interrupt, R7 flag cleared
    wr(2'd3, 8'h00);
    irq_cnt = 0;
    select_frame(1'b1);
    eb[0] = 8'h58;
    check_resp("R7 SAK without flag", 1, 0);
    chk(irq_cnt == 0, "R8 irq disabled", irq_cnt, 0);
    chk(active, "R6 active again", active, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule